// File: doc/BRIEF.md
# Two-Bit Pulse-Width Symbol Modulator

This block turns a serial bit stream into a pulse-width modulated line. Each pair of incoming bits forms one 2-bit symbol, and one pulse per carrier period carries it. A fast oversampling clock drives the block, and a tick counter divides one carrier period into equal phase slots. The pulse always rises at the first tick of a period. The symbol sets only where the pulse falls, so a receiver that measures its own timing can use the rising edge as its reference.

Bits come in with a valid strobe at any tick. Once a pair is complete it waits in a one-deep holding slot. At the next period boundary it moves into the active symbol. A period that starts with no symbol waiting sends no pulse and flags the shortfall. A level output toggles on every accepted bit, which gives the bit rate divided by two.

Top module: `pwm2_sym_mod`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears the tick counter, any half-collected bit pair, the waiting symbol and the active symbol. After that edge `pwm_out`, `sym_accept`, `half_rate` and `underflow` are all 0. A lone bit received before reset is never paired with a bit received after it.
- R2: Every two bits taken with `bit_valid` high make one symbol. The earlier of the two is bit 1 (MSB) and the later is bit 0.
- R3: `half_rate` inverts in the cycle after each clock edge at which `bit_valid` is high, and holds otherwise. It is therefore 1 exactly while one bit of a pair is held.
- R4: A carrier period is `PERIOD_TICKS` (default 10) clock cycles. Whenever a symbol is active, `pwm_out` rises only on tick 0 of a period.
- R5: With the defaults, symbol values 0, 1, 2 and 3 keep `pwm_out` high for 2, 4, 6 and 8 ticks from tick 0, which gives duty cycles of 20, 40, 60 and 80 percent.
- R6: A waiting symbol becomes active only at a period boundary, so a pulse width never changes inside a period. `sym_accept` is high for exactly tick 0 of the period in which a newly taken symbol is sent.
- R7: When no complete symbol is waiting at a period boundary, `pwm_out` stays low for the whole next period and `underflow` is high during that period. `underflow` and `sym_accept` are never high together.
- R8: If a second pair completes before the waiting symbol has been taken, the newer symbol replaces the older one, and the older one is never sent.
- R9: `ser_bit` has no effect while `bit_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, `PERIOD_TICKS` cycles per carrier period |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_bit | input | 1 | Serial data bit |
| bit_valid | input | 1 | High for one cycle per bit to be taken |
| pwm_out | output | 1 | Pulse-width modulated line |
| sym_accept | output | 1 | High on tick 0 of a period that sends a newly taken symbol |
| half_rate | output | 1 | Bit-rate-divided-by-two level |
| underflow | output | 1 | High during a period sent without a symbol |

## Verification
The hardest state to reach from the ports is two pairs completing inside one carrier period, so that the older waiting symbol must be dropped. A second hard case is a pair landing while a pulse is still high. The bench first lines up on tick 0 using its own period model. It then drives four bits on back-to-back ticks for the replacement case, and two bits at ticks 1 and 2 during a short pulse for the mid-pulse case. It checks the widths of the current and the following periods. A reset is also issued with half a pair held, to show that the lone bit is dropped.

// File: rtl/pwm2_pkg.sv
// Shared types for the two-bit pulse-width symbol modulator.
// Assumes symbols are always two bits wide.
package pwm2_pkg;
    localparam int SYM_BITS = 2;
    localparam int SYM_VALUES = 1 << SYM_BITS;
    typedef logic [SYM_BITS-1:0] sym_t;
endpackage

// File: rtl/pwm2_period_ctr.sv
// Carrier period counter: counts oversampling ticks 0..PERIOD_TICKS-1 and
// flags the last tick of each period.
// Assumes PERIOD_TICKS >= 2.
module pwm2_period_ctr #(
    parameter int PERIOD_TICKS = 10,
    localparam int TW = $clog2(PERIOD_TICKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [TW-1:0] tick,
    output logic          last_tick
);
    localparam logic [TW-1:0] LAST = TW'(PERIOD_TICKS - 1);

    // Purpose: last tick of the period, when the next symbol is chosen.
    assign last_tick = (tick == LAST);

    // Purpose: advance the tick and wrap at the end of the period.
    always_ff @(posedge clk) begin
        if (!rst_n)         tick <= '0;
        else if (last_tick) tick <= '0;
        else                tick <= tick + 1'b1;
    end
endmodule

// File: rtl/pwm2_pair_collect.sv
// Serial-to-symbol pairing: the first valid bit becomes the MSB, the
// second completes the symbol. The half-pair flag also serves as the
// bit-rate/2 level output.
// Assumes at most one bit per clock cycle.
module pwm2_pair_collect
    import pwm2_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ser_bit,
    input  logic bit_valid,
    output logic pair_vld,
    output sym_t pair_sym,
    output logic half_held
);
    logic msb_q;

    // Purpose: hold the first bit of a pair and toggle the half-pair flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msb_q     <= 1'b0;
            half_held <= 1'b0;
        end else if (bit_valid) begin
            if (!half_held) msb_q <= ser_bit;
            half_held <= !half_held;
        end
    end

    // Purpose: flag a completed pair in the cycle its second bit arrives.
    always_comb begin
        pair_vld = bit_valid && half_held;
        pair_sym = {msb_q, ser_bit};
    end
endmodule

// File: rtl/pwm2_edge_sel.sv
// Edge generator: builds one window line per candidate fall phase (each is
// high from tick 0 up to its phase) and selects one by symbol. The
// selected line is ORed with the period-start marker and gated by the
// active flag.
// Assumes PHASES-1 equals the number of symbol values and PERIOD_TICKS
// is a multiple of PHASES.
module pwm2_edge_sel
    import pwm2_pkg::*;
#(
    parameter int PERIOD_TICKS = 10,
    parameter int PHASES = 5,
    localparam int TW = $clog2(PERIOD_TICKS),
    localparam int STEP = PERIOD_TICKS / PHASES,
    localparam int NWIN = PHASES - 1
) (
    input  logic [TW-1:0] tick,
    input  sym_t          sym,
    input  logic          active,
    output logic          pwm
);
    logic [NWIN-1:0] win;
    logic            rise_mark;

    // Purpose: one delayed-carrier window per candidate fall phase.
    for (genvar k = 0; k < NWIN; k++) begin : g_win
        assign win[k] = (tick < TW'((k + 1) * STEP));
    end

    // Purpose: the rise at phase 0, ORed with the selected window.
    always_comb begin
        rise_mark = (tick == '0);
        pwm       = active && (rise_mark || win[sym]);
    end
endmodule

// File: rtl/pwm2_sym_mod.sv
// Top of the two-bit pulse-width symbol modulator. Pairs serial bits into
// symbols and keeps one symbol waiting. At each period boundary it either
// activates the waiting symbol or sends an empty period with underflow set.
// The output is decoded from registered state only.
// Assumes one bit per cycle at most and PERIOD_TICKS divisible by PHASES.
module pwm2_sym_mod
    import pwm2_pkg::*;
#(
    parameter int PERIOD_TICKS = 10,
    parameter int PHASES = 5,
    localparam int TW = $clog2(PERIOD_TICKS)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_bit,
    input  logic bit_valid,
    output logic pwm_out,
    output logic sym_accept,
    output logic half_rate,
    output logic underflow
);
    logic [TW-1:0] tick;
    logic          last_tick;
    logic          pair_vld;
    sym_t          pair_sym;
    logic          pend_vld;
    sym_t          pend_sym;
    logic          act_vld;
    sym_t          act_sym;

    pwm2_period_ctr #(.PERIOD_TICKS(PERIOD_TICKS)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .last_tick (last_tick)
    );

    pwm2_pair_collect u_pair (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_bit   (ser_bit),
        .bit_valid (bit_valid),
        .pair_vld  (pair_vld),
        .pair_sym  (pair_sym),
        .half_held (half_rate)
    );

    // Purpose: one-deep waiting slot; a newer pair overwrites an untaken one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_vld <= 1'b0;
            pend_sym <= '0;
        end else if (pair_vld) begin
            pend_vld <= 1'b1;
            pend_sym <= pair_sym;
        end else if (last_tick) begin
            pend_vld <= 1'b0;
        end
    end

    // Purpose: take the waiting symbol, or mark an empty period, at the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_vld    <= 1'b0;
            act_sym    <= '0;
            sym_accept <= 1'b0;
            underflow  <= 1'b0;
        end else begin
            sym_accept <= last_tick && pend_vld;
            if (last_tick) begin
                act_vld   <= pend_vld;
                underflow <= !pend_vld;
                if (pend_vld) act_sym <= pend_sym;
            end
        end
    end

    pwm2_edge_sel #(.PERIOD_TICKS(PERIOD_TICKS), .PHASES(PHASES)) u_edge (
        .tick   (tick),
        .sym    (act_sym),
        .active (act_vld),
        .pwm    (pwm_out)
    );
endmodule

// File: rtl/pwm2_sym_mod_chk.sv
// Property checker for pwm2_sym_mod, attached by bind. It observes ports
// and the internal tick and active symbol.
module pwm2_sym_mod_chk #(
    parameter int PERIOD_TICKS = 10,
    parameter int PHASES = 5,
    localparam int TW = $clog2(PERIOD_TICKS),
    localparam int STEP = PERIOD_TICKS / PHASES
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bit_valid,
    input logic          pwm_out,
    input logic          sym_accept,
    input logic          half_rate,
    input logic          underflow,
    input logic [TW-1:0] tick,
    input logic [1:0]    act_sym
);
    assert_half_rate_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |=> (half_rate != $past(half_rate)));

    assert_half_rate_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_valid |=> $stable(half_rate));

    assert_rise_at_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_out) |-> (tick == '0));

    assert_fall_on_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwm_out) |-> ((tick != '0) && ((int'(tick) % STEP) == 0)));

    assert_sym_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick != '0) |-> $stable(act_sym));

    assert_accept_at_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sym_accept |-> (tick == '0));

    assert_low_on_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> !pwm_out);

    assert_no_accept_with_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(underflow && sym_accept));
endmodule

bind pwm2_sym_mod pwm2_sym_mod_chk #(.PERIOD_TICKS(PERIOD_TICKS), .PHASES(PHASES)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_valid  (bit_valid),
    .pwm_out    (pwm_out),
    .sym_accept (sym_accept),
    .half_rate  (half_rate),
    .underflow  (underflow),
    .tick       (tick),
    .act_sym    (act_sym)
);

// File: tb/pwm2_sym_mod_tb_top.sv
// Bench for pwm2_sym_mod. A behavioural model built from queues and integers
// is compared with the outputs at every falling edge. Directed sequences
// then measure pulse widths for each requirement.
module pwm2_sym_mod_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PER = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_bit = 1'b0;
    logic bit_valid = 1'b0;
    logic pwm_out, sym_accept, half_rate, underflow;

    int n_chk = 0;
    int n_fail = 0;

    pwm2_sym_mod dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_bit    (ser_bit),
        .bit_valid  (bit_valid),
        .pwm_out    (pwm_out),
        .sym_accept (sym_accept),
        .half_rate  (half_rate),
        .underflow  (underflow)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Reference model state
    bit bitq[$];
    int m_tick = 0;
    int m_pend = -1;
    int m_act = -1;
    int m_acc = 0;
    int m_uf = 0;
    int m_half = 0;

    always @(posedge clk) begin
        int np;
        if (!rst_n) begin
            bitq.delete();
            m_tick = 0; m_pend = -1; m_act = -1; m_acc = 0; m_uf = 0; m_half = 0;
        end else begin
            np = -1;
            if (bit_valid) begin
                bitq.push_back(ser_bit);
                m_half = 1 - m_half;
                if (bitq.size() == 2) begin
                    np = 2 * int'(bitq[0]) + int'(bitq[1]);
                    bitq.delete();
                end
            end
            m_acc = 0;
            if (m_tick == PER - 1) begin
                if (m_pend >= 0) begin
                    m_act = m_pend; m_acc = 1; m_uf = 0; m_pend = -1;
                end else begin
                    m_act = -1; m_uf = 1;
                end
            end
            if (np >= 0) m_pend = np;
            m_tick = (m_tick + 1) % PER;
        end
    end

    // Every-cycle comparison against the model
    always @(negedge clk) begin
        int e_pwm;
        e_pwm = (m_act >= 0 && m_tick < 2 * (m_act + 1)) ? 1 : 0;
        chk(pwm_out === e_pwm[0], "R5", "pwm_out model", int'(pwm_out), e_pwm);
        chk(sym_accept === m_acc[0], "R6", "sym_accept model", int'(sym_accept), m_acc);
        chk(half_rate === m_half[0], "R3", "half_rate model", int'(half_rate), m_half);
        chk(underflow === m_uf[0], "R7", "underflow model", int'(underflow), m_uf);
    end

    task automatic drive_bit(input bit b);
        @(posedge clk); #1;
        ser_bit = b; bit_valid = 1'b1;
        @(posedge clk); #1;
        bit_valid = 1'b0;
    endtask

    task automatic drive_burst(input bit b0, input bit b1, input bit b2, input bit b3, input int n);
        bit bits[4];
        bits = '{b0, b1, b2, b3};
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            ser_bit = bits[i]; bit_valid = 1'b1;
        end
        @(posedge clk); #1;
        bit_valid = 1'b0;
    endtask

    task automatic wait_tick0();
        do @(negedge clk); while (m_tick != 0);
    endtask

    task automatic expect_width(input int w, input string req);
        int cnt;
        do @(negedge clk); while (!sym_accept);
        cnt = int'(pwm_out);
        for (int i = 1; i < PER; i++) begin
            @(negedge clk);
            cnt += int'(pwm_out);
        end
        chk(cnt == w, req, "pulse width", cnt, w);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(pwm_out == 1'b0 && sym_accept == 1'b0 && half_rate == 1'b0 && underflow == 1'b0,
            "R1", "outputs in reset", {pwm_out, sym_accept, half_rate, underflow}, 0);
        @(posedge clk); #1; rst_n = 1'b1;

        // R7: idle periods are empty and flagged
        repeat (15) @(negedge clk);
        chk(underflow == 1'b1, "R7", "underflow when idle", int'(underflow), 1);
        chk(pwm_out == 1'b0, "R7", "pwm low when idle", int'(pwm_out), 0);

        // R5/R2: each symbol width; bit order MSB first
        drive_burst(1'b0, 1'b0, 1'b0, 1'b0, 2); expect_width(2, "R5");
        drive_burst(1'b0, 1'b1, 1'b0, 1'b0, 2); expect_width(4, "R2");
        drive_burst(1'b1, 1'b0, 1'b0, 1'b0, 2); expect_width(6, "R2");
        drive_burst(1'b1, 1'b1, 1'b0, 1'b0, 2); expect_width(8, "R5");

        // R4: back-to-back symbols, rise each period at tick 0
        drive_burst(1'b0, 1'b1, 1'b1, 1'b0, 2);
        expect_width(4, "R4");

        // R8: two pairs inside one period, only the newer is sent
        wait_tick0();
        repeat (2) @(negedge clk);
        drive_burst(1'b0, 1'b1, 1'b1, 1'b1, 4);
        expect_width(8, "R8");
        @(negedge clk);
        chk(underflow == 1'b1, "R8", "older symbol dropped", int'(underflow), 1);

        // R6: a pair arriving mid-pulse does not change the current width
        drive_burst(1'b0, 1'b0, 1'b0, 1'b0, 2);
        begin
            int cnt;
            do @(negedge clk); while (!sym_accept);
            cnt = int'(pwm_out);
            for (int i = 1; i < PER; i++) begin
                @(posedge clk); #1;
                ser_bit = 1'b1; bit_valid = (i <= 2);
                @(negedge clk);
                cnt += int'(pwm_out);
            end
            bit_valid = 1'b0;
            chk(cnt == 2, "R6", "width kept mid-pulse", cnt, 2);
        end
        expect_width(8, "R6");

        // R9: ser_bit ignored while bit_valid is low
        wait_tick0();
        for (int i = 0; i < 2 * PER; i++) begin
            @(posedge clk); #1;
            ser_bit = ~ser_bit;
        end
        @(negedge clk);
        chk(half_rate == 1'b0, "R9", "half_rate unchanged", int'(half_rate), 0);
        chk(underflow == 1'b1 && pwm_out == 1'b0, "R9", "no symbol formed",
            {underflow, pwm_out}, 2);

        // R1: lone bit before reset is discarded
        drive_bit(1'b1);
        @(negedge clk);
        chk(half_rate == 1'b1, "R3", "half_rate after one bit", int'(half_rate), 1);
        @(posedge clk); #1; rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1; rst_n = 1'b1;
        @(negedge clk);
        chk(half_rate == 1'b0, "R1", "half pair cleared", int'(half_rate), 0);
        drive_burst(1'b0, 1'b0, 1'b0, 1'b0, 2);
        expect_width(2, "R1");

        repeat (3) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog all-requirements actual=timeout expected=completion");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule